// File: doc/BRIEF.md
# Multiplexed-Bus Address Decoder with Byte Ports

This block sits between an 8-bit processor whose low address byte and data byte share the same eight wires, a 32K static RAM, and a few byte-wide I/O ports. When the address strobe is high, the block captures the low address byte from the shared lines. It then joins that byte with the directly driven upper address bits to form a 15-bit RAM address.

All decoding is timed by the bus enable clock (E), which is registered once into the block clock domain. When A15 is set, the block drives an active-low RAM chip enable. When A15 is clear and A14 is set, it instead enables a one-of-eight port decoder. The decoder's select code is built from A13, A12 and the read/write line. As a result, the same 4K window reads an input port and writes a separate output latch.

Two 8-bit output latches are loaded on the falling edge of registered E:
- the motor latch, on code 6;
- the expansion latch, on code 0.

Codes 1 to 5 are brought out as spare active-low strobes. A lockout state machine keeps the RAM disabled for a set number of clocks after reset. It has two states: `LK_HOLD` after reset, and `LK_RUN` after the transition taken once the cycle count expires.

Top module: `mux_bus_decoder`

## Requirements
- R1: While `as_strb` is high at a clock edge, the low address byte on `ad_in` is captured; otherwise it is held. `ram_addr` is {`addr_hi[6:0]`, captured byte}.
- R2: `ram_ce_n` is 0 only when `addr_hi[7]` (A15) is 1, E registered one clock earlier is 1, and the lockout has ended; otherwise it is 1.
- R3: The port decoder is active only when A15=0, A14=1 and registered E is 1. Its code is {A13, A12, rw} with A13 as the MSB. Exactly `port_sel_n[code]` is 0 and every other bit is 1. When the decoder is inactive, all bits are 1.
- R4: Address bits A8 to A11 have no effect on the port decode, so each port aliases over a 4K window.
- R5: `ram_ce_n` low and any `port_sel_n` bit low never occur together.
- R6: `ad_oe` is 1 and `ad_out` equals `in_port` only while code 7 (a read) is selected. At all other times `ad_oe` is 0.
- R7: On a clock where registered E is 1 and the E input is 0, the motor latch loads `ad_in` if code 6 is selected, and the expansion latch loads `ad_in` if code 0 is selected. Both latches reset to 0x00.
- R8: Writes to codes 1 to 5, port reads, and RAM accesses leave both output latches unchanged.
- R9: After reset, the lockout holds the RAM disabled for `LOCK_CYCLES` clocks (default 1024), regardless of the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ad_in | input | 8 | Shared address/data lines, incoming |
| ad_out | output | 8 | Data driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| as_strb | input | 1 | Address strobe |
| rw | input | 1 | 1 = read, 0 = write |
| e_clk | input | 1 | Bus enable clock |
| addr_hi | input | 8 | Address bits A8 to A15 |
| in_port | input | 8 | Input port byte |
| ram_addr | output | 15 | RAM address |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| port_sel_n | output | 8 | One-of-eight port strobes, active low |
| motor_q | output | 8 | Motor output latch |
| exp_q | output | 8 | Expansion output latch |

## Verification
The bench checks RAM access just before and well after the lockout ends. A design with a broken lockout would enable the RAM too early or never. It runs every select code, plus the A14=0 and E-low cases. A design that swapped the code bit order, or that decoded while E was low, would strobe the wrong port.

It writes to spare codes and reads through the shared window, then checks that neither latch moved. A decoder that ignored `rw` would corrupt the motor latch on input reads. It also changes the shared lines after the strobe has dropped; a latch that is transparent instead of strobed would let the RAM address follow the data byte.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
    localparam int BYTE_W   = 8;
    localparam int SEL_N    = 8;
    localparam int SEL_W    = $clog2(SEL_N);
    localparam int RAM_AW   = 15;
    localparam logic [SEL_W-1:0] CODE_EXP   = 3'd0;
    localparam logic [SEL_W-1:0] CODE_MOTOR = 3'd6;
    localparam logic [SEL_W-1:0] CODE_INPUT = 3'd7;

    typedef enum logic {
        LK_HOLD = 1'b0,
        LK_RUN  = 1'b1
    } lock_state_e;
endpackage

// File: rtl/lockout_fsm.sv
module lockout_fsm #(
    parameter int LOCK_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic ram_ok
);
    import mux_bus_pkg::*;

    localparam int CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);

    lock_state_e state, state_nx;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            LK_HOLD: if (cnt == LAST) state_nx = LK_RUN;
            LK_RUN:  state_nx = LK_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LK_HOLD;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == LK_HOLD && cnt != LAST) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        unique case (state)
            LK_HOLD: ram_ok = 1'b0;
            LK_RUN:  ram_ok = 1'b1;
        endcase
    end
endmodule

// File: rtl/addr_lo_latch.sv
module addr_lo_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] bus,
    output logic [W-1:0] lo
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lo <= '0;
        else if (strobe) lo <= bus;
    end
endmodule

// File: rtl/port_decode.sv
module port_decode
    import mux_bus_pkg::*;
(
    input  logic [7:0]       addr_hi,
    input  logic             rw,
    input  logic             e_act,
    input  logic             ram_ok,
    output logic             ram_ce_n,
    output logic [SEL_N-1:0] port_sel_n,
    output logic             rd_input
);
    logic             dec_en;
    logic [SEL_W-1:0] code;

    assign dec_en   = !addr_hi[7] && addr_hi[6] && e_act;
    assign code     = {addr_hi[5], addr_hi[4], rw};
    assign ram_ce_n = !(addr_hi[7] && e_act && ram_ok);
    assign rd_input = dec_en && (code == CODE_INPUT);

    for (genvar g = 0; g < SEL_N; g++) begin : g_sel
        assign port_sel_n[g] = !(dec_en && (code == SEL_W'(g)));
    end
endmodule

// File: rtl/byte_latch.sv
module byte_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/mux_bus_decoder.sv
module mux_bus_decoder #(
    parameter int LOCK_CYCLES = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  ad_in,
    output logic [7:0]  ad_out,
    output logic        ad_oe,
    input  logic        as_strb,
    input  logic        rw,
    input  logic        e_clk,
    input  logic [7:0]  addr_hi,
    input  logic [7:0]  in_port,
    output logic [14:0] ram_addr,
    output logic        ram_ce_n,
    output logic [7:0]  port_sel_n,
    output logic [7:0]  motor_q,
    output logic [7:0]  exp_q
);
    import mux_bus_pkg::*;

    logic             e_q;
    logic             e_fall;
    logic             ram_ok;
    logic             rd_input;
    logic [BYTE_W-1:0] lo_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= 1'b0;
        else        e_q <= e_clk;
    end
    assign e_fall = e_q && !e_clk;

    lockout_fsm #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk(clk), .rst_n(rst_n), .ram_ok(ram_ok)
    );

    addr_lo_latch #(.W(BYTE_W)) u_lo (
        .clk(clk), .rst_n(rst_n), .strobe(as_strb), .bus(ad_in), .lo(lo_byte)
    );
    assign ram_addr = {addr_hi[6:0], lo_byte};

    port_decode u_dec (
        .addr_hi(addr_hi), .rw(rw), .e_act(e_q), .ram_ok(ram_ok),
        .ram_ce_n(ram_ce_n), .port_sel_n(port_sel_n), .rd_input(rd_input)
    );

    byte_latch #(.W(BYTE_W)) u_motor (
        .clk(clk), .rst_n(rst_n),
        .load(e_fall && !port_sel_n[CODE_MOTOR]), .d(ad_in), .q(motor_q)
    );

    byte_latch #(.W(BYTE_W)) u_exp (
        .clk(clk), .rst_n(rst_n),
        .load(e_fall && !port_sel_n[CODE_EXP]), .d(ad_in), .q(exp_q)
    );

    assign ad_oe  = rd_input;
    assign ad_out = rd_input ? in_port : '0;
endmodule

// File: rtl/mux_bus_decoder_chk.sv
module mux_bus_decoder_chk #(
    parameter int LOCK_CYCLES = 1024
) (
    input logic        clk,
    input logic        rst_n,
    input logic        as_strb,
    input logic        ad_oe,
    input logic [14:0] ram_addr,
    input logic        ram_ce_n,
    input logic [7:0]  port_sel_n,
    input logic [7:0]  motor_q,
    input logic [7:0]  exp_q
);
    logic [31:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 32'hFFFF_FFFF) since_rst <= since_rst + 1;
    end

    AST_RAM_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_ce_n |-> (port_sel_n == 8'hFF)) else $error("excl"); // R5
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~port_sel_n)) else $error("onehot"); // R3
    AST_OE_ONLY_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> !port_sel_n[7]) else $error("oe"); // R6
    AST_MOTOR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(motor_q) |-> $past(!port_sel_n[6])) else $error("motor"); // R7
    AST_EXP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(exp_q) |-> $past(!port_sel_n[0])) else $error("exp"); // R8
    AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(as_strb) |-> $stable(ram_addr[7:0])) else $error("lo"); // R1
    AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_ce_n |-> (since_rst >= 32'(LOCK_CYCLES))) else $error("lock"); // R9
endmodule

bind mux_bus_decoder mux_bus_decoder_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .as_strb(as_strb), .ad_oe(ad_oe),
    .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .port_sel_n(port_sel_n),
    .motor_q(motor_q), .exp_q(exp_q)
);

// File: tb/mux_bus_decoder_tb.sv
module mux_bus_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ad_in = '0;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic        as_strb = 1'b0;
    logic        rw = 1'b1;
    logic        e_clk = 1'b0;
    logic [7:0]  addr_hi = '0;
    logic [7:0]  in_port = 8'hA5;
    logic [14:0] ram_addr;
    logic        ram_ce_n;
    logic [7:0]  port_sel_n;
    logic [7:0]  motor_q;
    logic [7:0]  exp_q;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mux_bus_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .as_strb(as_strb), .rw(rw), .e_clk(e_clk), .addr_hi(addr_hi),
        .in_port(in_port), .ram_addr(ram_addr), .ram_ce_n(ram_ce_n),
        .port_sel_n(port_sel_n), .motor_q(motor_q), .exp_q(exp_q)
    );

    // {addr_hi, rw, e, exp ram_ce_n, exp port_sel_n, exp ad_oe}
    localparam int NV = 14;
    localparam logic [19:0] VEC [NV] = '{
        {8'h80, 1'b1, 1'b1, 1'b0, 8'hFF, 1'b0},  // R2 RAM read
        {8'hFF, 1'b0, 1'b1, 1'b0, 8'hFF, 1'b0},  // R2 RAM write
        {8'h80, 1'b1, 1'b0, 1'b1, 8'hFF, 1'b0},  // R2 E low
        {8'h70, 1'b1, 1'b1, 1'b1, 8'h7F, 1'b1},  // R3 R6 code 7
        {8'h7F, 1'b0, 1'b1, 1'b1, 8'hBF, 1'b0},  // R3 R4 code 6
        {8'h40, 1'b0, 1'b1, 1'b1, 8'hFE, 1'b0},  // R3 code 0
        {8'h40, 1'b1, 1'b1, 1'b1, 8'hFD, 1'b0},  // R3 code 1
        {8'h55, 1'b0, 1'b1, 1'b1, 8'hFB, 1'b0},  // R3 code 2
        {8'h5A, 1'b1, 1'b1, 1'b1, 8'hF7, 1'b0},  // R3 R4 code 3
        {8'h60, 1'b0, 1'b1, 1'b1, 8'hEF, 1'b0},  // R3 code 4
        {8'h6F, 1'b1, 1'b1, 1'b1, 8'hDF, 1'b0},  // R3 R4 code 5
        {8'h30, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b0},  // R3 A14 low
        {8'h70, 1'b1, 1'b0, 1'b1, 8'hFF, 1'b0},  // R3 R6 E low
        {8'h0C, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b0}   // R3 low page
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_step(input logic [7:0] hi, input logic r, input logic e, input logic [7:0] d);
        @(negedge clk);
        addr_hi = hi; rw = r; e_clk = e; ad_in = d;
    endtask

    task automatic latch_write(input logic [7:0] hi, input logic r, input logic [7:0] d);
        bus_step(hi, r, 1'b1, d);
        bus_step(hi, r, 1'b0, d);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R7 reset motor", motor_q, 8'h00);
        chk("R7 reset exp", exp_q, 8'h00);
        chk("R3 reset sel", port_sel_n, 8'hFF);
        chk("R2 reset ce", ram_ce_n, 1'b1);

        // R9 lockout: RAM address with E high stays disabled
        bus_step(8'h80, 1'b1, 1'b1, 8'h00);
        repeat (900) @(negedge clk);
        chk("R9 lockout hold", ram_ce_n, 1'b1);
        repeat (200) @(negedge clk);
        chk("R9 lockout over", ram_ce_n, 1'b0);
        bus_step(8'h80, 1'b1, 1'b0, 8'h00);
        @(negedge clk);

        // table walk
        for (int i = 0; i < NV; i++) begin
            bus_step(VEC[i][19:12], VEC[i][11], VEC[i][10], 8'h00);
            @(negedge clk);
            chk($sformatf("R2 ce vec%0d", i), ram_ce_n, VEC[i][9]);
            chk($sformatf("R3 sel vec%0d", i), port_sel_n, VEC[i][8:1]);
            chk($sformatf("R6 oe vec%0d", i), ad_oe, VEC[i][0]);
        end

        // R6 read data
        in_port = 8'h3E;
        bus_step(8'h7A, 1'b1, 1'b1, 8'h00);
        @(negedge clk);
        chk("R6 read data", ad_out, 8'h3E);
        bus_step(8'h7A, 1'b1, 1'b0, 8'h00);

        // R1 address capture and hold
        @(negedge clk);
        addr_hi = 8'hB3; ad_in = 8'h5C; as_strb = 1'b1;
        @(negedge clk);
        as_strb = 1'b0; ad_in = 8'hAA;
        @(negedge clk);
        chk("R1 ram_addr", ram_addr, 15'h335C);
        @(negedge clk);
        chk("R1 hold", ram_addr, 15'h335C);

        // R7 latch loads
        latch_write(8'h7C, 1'b0, 8'h3C);
        chk("R7 motor load", motor_q, 8'h3C);
        chk("R7 exp kept", exp_q, 8'h00);
        latch_write(8'h41, 1'b0, 8'hC3);
        chk("R7 exp load", exp_q, 8'hC3);
        chk("R7 motor kept", motor_q, 8'h3C);

        // R8 no effect from other codes, reads, RAM
        latch_write(8'h50, 1'b0, 8'h11);   // code 2
        latch_write(8'h60, 1'b0, 8'h22);   // code 4
        latch_write(8'h70, 1'b1, 8'h33);   // read code 7
        latch_write(8'h40, 1'b1, 8'h44);   // read code 1
        latch_write(8'hF0, 1'b0, 8'h55);   // RAM write
        chk("R8 motor unchanged", motor_q, 8'h3C);
        chk("R8 exp unchanged", exp_q, 8'hC3);

        // R4 alias: far end of window still loads motor latch
        latch_write(8'h7F, 1'b0, 8'h99);
        chk("R4 alias motor", motor_q, 8'h99);

        // R5 RAM and ports never together
        bus_step(8'hC0, 1'b0, 1'b1, 8'h00);
        @(negedge clk);
        chk("R5 ram only", {ram_ce_n, port_sel_n}, {1'b0, 8'hFF});
        bus_step(8'h00, 1'b1, 1'b0, 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule